// File: doc/BRIEF.md
# Clock Mode Sequencing Controller

This block decides which clock feeds a small processor core and how far that clock is divided. Software writes a full 9-bit control word through a single write port. Before the word is stored, the block checks it against the allowed set of clock-mode transitions and against the ordering rules on individual bits.

A legal word is stored, and the outputs follow it on the next clock edge. An illegal word is dropped, the stored word is kept, and an error strobe is raised for one cycle.

The clock sources are the main oscillator, a PLL, a slow sub oscillator and an internal ring oscillator. Each source is represented only by status inputs: main stable, sub stable, PLL locked, and PLL configured at or above the fast threshold. From the stored word the block drives a 2-bit source code, a 3-bit divide exponent and a wait-state select.

Control word layout:

| Bit | Meaning |
|-----|---------|
| 0 | Divide-by-8 |
| 2:1 | Ratio |
| 3 | Sub select |
| 4 | Ring select |
| 5 | PLL on |
| 6 | Two wait states |
| 7 | Oscillation-stop detection enable |
| 8 | Ring low-power |

Source codes are 0 main, 1 PLL, 2 sub and 3 ring. The source is chosen by priority: PLL, then sub, then ring, then main.

Top module: `clk_mode_seq`

## Requirements
- R1: After reset the stored word is 0x001. The outputs are then source 0 (main), exponent 3, wait select 0 and error 0.
- R2: For main and ring sources the exponent is 3 when bit 0 is 1. Otherwise ratio codes 00, 01, 10 and 11 give exponents 0, 1, 2 and 4.
- R3: Bit 5 gives source 1 with exponent 0. Otherwise bit 3 gives source 2 with exponent 0, and otherwise bit 4 gives source 3.
- R4: An accepted write appears on the stored-word readback and on the outputs at the next rising edge, with the error output low.
- R5: A rejected write leaves the stored word unchanged and raises the error output for exactly the one cycle after the write.
- R6: Setting bit 5 is accepted only when the stored word has bits 5:0 all zero (main clock, undivided) and the PLL lock input is high.
- R7: Clearing bit 5 is accepted only when the new word has bits 5:0 all zero.
- R8: While the PLL is on in the stored or the new word, and the fast-PLL input is high, a new word with bit 6 = 0 is rejected. Entering PLL mode with the fast-PLL input high also requires bit 6 to be already set in the stored word.
- R9: Clearing bit 4 is rejected unless bit 0 of the stored word is 1.
- R10: A write that clears bit 0 must keep bits 2:1 equal to their stored value; otherwise it is rejected.
- R11: While bit 7 of the stored word is 1, a write that changes any of bits 5:0 or bit 8 is rejected. Writes that change only bits 6 and 7 remain allowed.
- R12: With bit 8 set, a word with bit 0 = 0 and ratio 01 or 10 is rejected, so only exponents 0, 3 and 4 are reachable.
- R13: A change of source to main needs the main-stable input high. A change of source to sub needs the sub-stable input high.
- R14: Malformed words are rejected. These are: bits 3 and 4 both set; bit 5 set together with any of bits 4:0; and bit 8 set without bit 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 9 | Requested control word |
| main_ok | input | 1 | Main oscillator stable |
| sub_ok | input | 1 | Sub oscillator stable |
| pll_lock | input | 1 | PLL locked |
| pll_hi | input | 1 | PLL configured at or above the fast threshold |
| ctrl_rd | output | 9 | Stored control word |
| src_sel | output | 2 | Source code: 0 main, 1 PLL, 2 sub, 3 ring |
| div_exp | output | 3 | Divide exponent (clock divided by 2^div_exp) |
| wait_sel | output | 1 | 1 selects two wait states |
| wr_err | output | 1 | One-cycle strobe for a rejected write |

## Verification
A directed walk covers the main paths. It steps through every divider ratio and into and out of PLL mode. It probes the wait-state ordering with the fast flag on and off, and it enters and leaves ring mode with bit 0 clear and then set. It also covers ring low-power, sub entry with the stable flag low, and oscillation-stop lock.

A sweep then drives every one of the 512 words from seven prepared starting modes (reset, undivided main, PLL, ring /8, ring low-power /16, sub, and detection-locked), each with two complementary flag patterns. This separates rules that depend on the stored word from rules that depend only on the new word or on the status flags. For every write, an arithmetic model in the bench predicts acceptance, the stored word, source, exponent and wait select.

// File: rtl/clk_mode_seq.sv
module clk_mode_seq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [8:0] wr_data,
  input  logic       main_ok,
  input  logic       sub_ok,
  input  logic       pll_lock,
  input  logic       pll_hi,
  output logic [8:0] ctrl_rd,
  output logic [1:0] src_sel,
  output logic [2:0] div_exp,
  output logic       wait_sel,
  output logic       wr_err
);
  localparam int B_D8 = 0, B_SUB = 3, B_RING = 4, B_PLL = 5, B_WAIT = 6, B_OSD = 7, B_LP = 8;
  localparam logic [8:0] RST_WORD = 9'h001;
  localparam logic [1:0] S_MAIN = 2'd0, S_PLL = 2'd1, S_SUB = 2'd2, S_RING = 2'd3;

  logic [8:0] cq;
  logic       err_q;

  function automatic logic [1:0] src_of(input logic [8:0] x);
    if (x[B_PLL])       return S_PLL;
    else if (x[B_SUB])  return S_SUB;
    else if (x[B_RING]) return S_RING;
    else                return S_MAIN;
  endfunction

  function automatic logic [2:0] exp_of(input logic [8:0] x);
    if (x[B_PLL] || x[B_SUB]) return 3'd0;
    if (x[B_D8])              return 3'd3;
    case (x[2:1])
      2'b00:   return 3'd0;
      2'b01:   return 3'd1;
      2'b10:   return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  wire [8:0] n = wr_data;
  wire [1:0] src_c = src_of(cq);
  wire [1:0] src_n = src_of(n);
  wire       hs_c  = (cq[5:0] == 6'd0);
  wire       hs_n  = (n[5:0] == 6'd0);
  wire       mid_ratio = (n[2:1] == 2'b01) || (n[2:1] == 2'b10);

  wire bad_form = (n[B_SUB] & n[B_RING])
                | (n[B_PLL] & (n[4:0] != 5'd0))
                | (n[B_LP] & ~n[B_RING])
                | (n[B_LP] & ~n[B_D8] & mid_ratio);
  wire cfg_chg  = ({n[B_LP], n[5:0]} != {cq[B_LP], cq[5:0]});
  wire bad_osd  = cq[B_OSD] & cfg_chg;
  wire bad_pin  = ~cq[B_PLL] & n[B_PLL] & (~hs_c | ~pll_lock | (pll_hi & ~cq[B_WAIT]));
  wire bad_pout = cq[B_PLL] & ~n[B_PLL] & ~hs_n;
  wire bad_wait = (cq[B_PLL] | n[B_PLL]) & pll_hi & ~n[B_WAIT];
  wire bad_ring = cq[B_RING] & ~n[B_RING] & ~cq[B_D8];
  wire bad_d8   = cq[B_D8] & ~n[B_D8] & (n[2:1] != cq[2:1]);
  wire bad_main = (src_n == S_MAIN) & (src_c != S_MAIN) & ~main_ok;
  wire bad_sub  = (src_n == S_SUB) & (src_c != S_SUB) & ~sub_ok;
  wire reject   = bad_form | bad_osd | bad_pin | bad_pout | bad_wait
                | bad_ring | bad_d8 | bad_main | bad_sub;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cq    <= RST_WORD;
      err_q <= 1'b0;
    end else begin
      err_q <= wr_en & reject;
      if (wr_en && !reject) cq <= n;
    end
  end

  assign ctrl_rd  = cq;
  assign src_sel  = src_c;
  assign div_exp  = exp_of(cq);
  assign wait_sel = cq[B_WAIT];
  assign wr_err   = err_q;

  AST_ERR_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n) wr_err |-> $past(wr_en)); // R5
  AST_ERR_HOLDS_WORD:  assert property (@(posedge clk) disable iff (!rst_n) wr_err |-> $stable(ctrl_rd)); // R5
  AST_PLL_ENTRY:       assert property (@(posedge clk) disable iff (!rst_n)
                         $rose(src_sel == S_PLL) |-> ($past(src_sel) == S_MAIN && $past(div_exp) == 3'd0)); // R6
  AST_PLL_EXIT:        assert property (@(posedge clk) disable iff (!rst_n)
                         $fell(src_sel == S_PLL) |-> (src_sel == S_MAIN && div_exp == 3'd0)); // R7
  AST_WAIT_ORDER:      assert property (@(posedge clk) disable iff (!rst_n)
                         $fell(wait_sel) |-> !($past(pll_hi) && ($past(src_sel) == S_PLL || src_sel == S_PLL))); // R8
  AST_RING_EXIT:       assert property (@(posedge clk) disable iff (!rst_n)
                         ($past(src_sel) == S_RING && src_sel != S_RING) |-> $past(div_exp) == 3'd3); // R9
  AST_OSD_LOCK:        assert property (@(posedge clk) disable iff (!rst_n)
                         $past(ctrl_rd[B_OSD]) |-> ($stable(ctrl_rd[5:0]) && $stable(ctrl_rd[B_LP]))); // R11
  AST_LP_RATIOS:       assert property (@(posedge clk) disable iff (!rst_n)
                         ctrl_rd[B_LP] |-> (div_exp != 3'd1 && div_exp != 3'd2)); // R12
endmodule

// File: tb/clk_mode_seq_tb.sv
module clk_mode_seq_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [8:0] wr_data = 9'h000;
  logic       main_ok = 1'b1, sub_ok = 1'b1, pll_lock = 1'b1, pll_hi = 1'b0;
  logic [8:0] ctrl_rd;
  logic [1:0] src_sel;
  logic [2:0] div_exp;
  logic       wait_sel, wr_err;

  int n_run = 0, n_fail = 0;
  logic [8:0] cur = 9'h001;

  always #5 clk = ~clk;

  clk_mode_seq u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .main_ok(main_ok), .sub_ok(sub_ok), .pll_lock(pll_lock), .pll_hi(pll_hi),
    .ctrl_rd(ctrl_rd), .src_sel(src_sel), .div_exp(div_exp),
    .wait_sel(wait_sel), .wr_err(wr_err)
  );

  function automatic int ref_src(input logic [8:0] x);
    return x[5] ? 1 : x[3] ? 2 : x[4] ? 3 : 0;
  endfunction

  function automatic int ref_exp(input logic [8:0] x);
    int r;
    if (x[5] || x[3]) return 0;
    if (x[0]) return 3;
    r = int'(x[2:1]);
    return (r == 3) ? 4 : r;
  endfunction

  // f = {pll_hi, pll_lock, sub_ok, main_ok}
  function automatic bit ref_ok(input logic [8:0] c, input logic [8:0] w, input logic [3:0] f);
    int sc = ref_src(c);
    int sw = ref_src(w);
    if (w[3] && w[4]) return 0;
    if (w[5] && w[4:0] != 0) return 0;
    if (w[8] && !w[4]) return 0;
    if (w[8] && !w[0] && (w[2:1] == 2'd1 || w[2:1] == 2'd2)) return 0;
    if (c[7] && {w[8], w[5:0]} != {c[8], c[5:0]}) return 0;
    if (!c[5] && w[5]) begin
      if (c[5:0] != 0 || !f[2]) return 0;
      if (f[3] && !c[6]) return 0;
    end
    if (c[5] && !w[5] && w[5:0] != 0) return 0;
    if ((c[5] || w[5]) && f[3] && !w[6]) return 0;
    if (c[4] && !w[4] && !c[0]) return 0;
    if (c[0] && !w[0] && w[2:1] != c[2:1]) return 0;
    if (sw == 0 && sc != 0 && !f[0]) return 0;
    if (sw == 2 && sc != 2 && !f[1]) return 0;
    return 1;
  endfunction

  task automatic check_state(input logic [8:0] ew, input bit eerr, input string tag);
    n_run++;
    if (ctrl_rd !== ew || wr_err !== eerr || int'(src_sel) != ref_src(ew) ||
        int'(div_exp) != ref_exp(ew) || wait_sel !== ew[6]) begin
      n_fail++;
      $display("FAIL %s: word=%h err=%b src=%0d exp=%0d wait=%b, expected word=%h err=%b src=%0d exp=%0d wait=%b",
               tag, ctrl_rd, wr_err, src_sel, div_exp, wait_sel,
               ew, eerr, ref_src(ew), ref_exp(ew), ew[6]);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    wr_en = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    cur = 9'h001;
  endtask

  task automatic apply(input logic [8:0] w, input bit ok, input string tag);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = w;
    @(negedge clk);
    wr_en = 1'b0;
    if (ok) begin
      cur = w;
      check_state(cur, 1'b0, {"R4 ", tag});
    end else begin
      check_state(cur, 1'b1, {"R5 ", tag});
    end
    @(negedge clk);
    if (!ok) check_state(cur, 1'b0, "R5 strobe length");
  endtask

  task automatic set_flags(input logic [3:0] f);
    {pll_hi, pll_lock, sub_ok, main_ok} = f;
  endtask

  task automatic prep(input int k);
    set_flags(4'b0111);
    case (k)
      1: apply(9'h000, 1, "prep high-speed");
      2: begin
           set_flags(4'hF);
           apply(9'h000, 1, "prep");
           apply(9'h040, 1, "prep");
           apply(9'h060, 1, "prep pll");
         end
      3: apply(9'h011, 1, "prep ring /8");
      4: begin
           apply(9'h011, 1, "prep");
           apply(9'h111, 1, "prep");
           apply(9'h117, 1, "prep");
           apply(9'h116, 1, "prep ring lp /16");
         end
      5: apply(9'h009, 1, "prep sub");
      6: apply(9'h081, 1, "prep osd");
      default: ;
    endcase
  endtask

  initial begin
    #1900000;
    n_fail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    @(negedge clk);
    check_state(9'h001, 1'b0, "R1 reset state");

    apply(9'h002, 0, "R10 ratio change while clearing div8");
    apply(9'h003, 1, "R2 ratio set under div8 keeps /8");
    apply(9'h002, 1, "R2 R10 /2 after ordered clear");
    apply(9'h004, 1, "R2 /4");
    apply(9'h006, 1, "R2 /16");
    apply(9'h020, 0, "R6 PLL entry from /16");
    apply(9'h000, 1, "R2 /1 high-speed");
    pll_lock = 1'b0;
    apply(9'h020, 0, "R6 PLL entry without lock");
    pll_lock = 1'b1;
    pll_hi = 1'b1;
    apply(9'h060, 0, "R8 fast PLL entry before wait set");
    apply(9'h040, 1, "R8 wait raised first");
    apply(9'h060, 1, "R6 R3 PLL entry");
    apply(9'h020, 0, "R8 wait drop while fast PLL on");
    apply(9'h041, 0, "R7 PLL exit to /8");
    apply(9'h040, 1, "R7 PLL exit to high-speed");
    apply(9'h000, 1, "R8 wait drop after PLL off");
    pll_hi = 1'b0;

    apply(9'h001, 1, "R2 back to /8");
    apply(9'h011, 1, "R3 ring /8");
    main_ok = 1'b0;
    apply(9'h001, 0, "R13 main unstable");
    main_ok = 1'b1;
    apply(9'h013, 1, "R2 ring ratio under div8");
    apply(9'h012, 1, "R2 ring /2");
    apply(9'h002, 0, "R9 ring exit with div8 clear");
    apply(9'h013, 1, "R9 div8 set in ring");
    apply(9'h003, 1, "R9 ring exit with div8 set");

    apply(9'h013, 1, "R3 ring again");
    apply(9'h113, 1, "R12 low-power /8");
    apply(9'h112, 0, "R12 low-power /2");
    apply(9'h117, 1, "R12 ratio 11 under div8");
    apply(9'h116, 1, "R12 low-power /16");
    apply(9'h117, 1, "R12 back to /8");
    apply(9'h017, 1, "R3 leave low-power");
    apply(9'h007, 1, "R9 ring exit");

    sub_ok = 1'b0;
    apply(9'h00F, 0, "R13 sub unstable");
    sub_ok = 1'b1;
    apply(9'h00F, 1, "R3 sub undivided");
    apply(9'h08F, 1, "R11 detection enable only");
    apply(9'h087, 0, "R11 source change while detection on");
    apply(9'h00F, 1, "R11 detection disable only");
    apply(9'h007, 1, "R13 back to main");

    apply(9'h019, 0, "R14 sub and ring");
    apply(9'h021, 0, "R14 PLL with div8");
    apply(9'h101, 0, "R14 low-power without ring");

    for (int k = 0; k < 7; k++) begin
      for (int w = 0; w < 512; w++) begin
        for (int p = 0; p < 2; p++) begin
          logic [3:0] f;
          logic [8:0] wv;
          wv = 9'(w);
          f = wv[3:0] ^ wv[7:4];
          if (p == 1) f = ~f;
          do_reset();
          prep(k);
          set_flags(f);
          apply(wv, ref_ok(cur, wv, f), "R5 R4 sweep");
        end
      end
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule